// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss in hardware. When the translation buffer reports a miss, the walker holds the processor stalled and reads a first-level descriptor from external memory. The root table sits at physical address zero and is indexed by the top ten bits of the virtual address. If that descriptor is not marked valid, the walker raises a page fault and stays there until reset. Otherwise it reads the second-level descriptor. That read is addressed by the base field of the first descriptor together with the middle ten virtual address bits.

The second descriptor is repacked into the coprocessor's low-entry register format and written into that register through a register-write port. The walker then pulses the translation buffer's write enable and requests an exception return, so that the faulting instruction runs again. Memory is reached through a Wishbone-style single-beat read master. The virtual address is not stored inside the block: the surrounding pipeline must hold it steady for as long as the stall output is high.

Top module: `ptw_walker`

## Requirements
- R1: While reset is low and in the idle state after reset, every output is zero: stall, page fault, TLB write, coprocessor select/move/return, coprocessor address and data, cyc, stb, we, sel, memory address and memory write data.
- R2: In the idle state, stall stays low while the miss input is low. A miss seen high in an idle cycle makes the next cycle a first-level read with stall high. This also holds in the idle cycle that directly follows an exception return.
- R3: The first-level read address is 20 zero bits, then virtual address bits [31:22], then 2 zero bits.
- R4: During each read, cyc and stb are high, we is low and sel is 4'b1111. The read and its address hold unchanged until ack is high at a clock edge. At that edge the read data is captured and the strobes drop in the next cycle.
- R5: A first-level descriptor with bit 31 clear drives page fault high, with stall high, one cycle after the read completes. Page fault then stays high, with no further memory access, until reset.
- R6: A first-level descriptor with bit 31 set starts the second-level read one cycle after the first read completes. Its address is 6 zero bits, then descriptor bits [13:0], then virtual address bits [21:12], then 2 zero bits.
- R7: In the cycle after the second read completes, coprocessor move and coprocessor select are high for one cycle. The coprocessor address is 5'b00010 and the data is second-descriptor bits [19:0], then bits [23:20], then 8 zero bits.
- R8: TLB write is high for exactly the one cycle after the coprocessor move.
- R9: Exception return and coprocessor select are high for the one cycle after the TLB write. The next cycle is idle with stall low.
- R10: Stall is high in every non-idle cycle. Memory we and write data are always zero. Outside the two reads, cyc, stb and sel are zero.
- R11: At most one of coprocessor move, exception return, TLB write and page fault is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_i | input | 1 | Translation miss request |
| vaddr_i | input | 32 | Missing virtual address, held stable while stall is high |
| mem_ack_i | input | 1 | Memory read completion |
| mem_rdata_i | input | 32 | Memory read data |
| mem_cyc_o | output | 1 | Bus cycle in progress |
| mem_stb_o | output | 1 | Bus strobe |
| mem_we_o | output | 1 | Bus write enable (always low) |
| mem_sel_o | output | 4 | Byte lane select |
| mem_addr_o | output | 32 | Physical read address |
| mem_wdata_o | output | 32 | Bus write data (always zero) |
| cop_sel_o | output | 1 | Claims the coprocessor write port for this walker |
| cop_move_o | output | 1 | Coprocessor register move |
| cop_ret_o | output | 1 | Exception return request |
| cop_addr_o | output | 5 | Coprocessor register index |
| cop_data_o | output | 32 | Coprocessor register data |
| tlb_we_o | output | 1 | Translation buffer write enable |
| page_fault_o | output | 1 | Page fault indication |
| stall_o | output | 1 | Processor stall |

## Verification
Two functions can land on the same clock edge. In one case the ack completing a read arrives in the very first cycle the strobes are up, so the descriptor is captured on that edge. In the other, the idle cycle after an exception return sees a fresh miss and starts a new walk. The bench provokes the first by answering with zero wait states, and the second by holding the miss input high across a whole walk. It then judges the exact order of outputs through its expected-event queue: one idle cycle with stall low, then the next first-level read, and every descriptor captured correctly despite the zero-wait handshakes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_FETCH_ROOT = 3'd1,
    ST_TEST_ROOT  = 3'd2,
    ST_FAULT      = 3'd3,
    ST_FETCH_LEAF = 3'd4,
    ST_WRITE_LO   = 3'd5,
    ST_FILL_TLB   = 3'd6,
    ST_RESUME     = 3'd7
  } walk_state_e;

endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss,
  input  logic        ack,
  input  logic        root_valid,
  output walk_state_e state
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (miss) state_d = ST_FETCH_ROOT;
      ST_FETCH_ROOT: if (ack)  state_d = ST_TEST_ROOT;
      ST_TEST_ROOT:  state_d = root_valid ? ST_FETCH_LEAF : ST_FAULT;
      ST_FAULT:      state_d = ST_FAULT;
      ST_FETCH_LEAF: if (ack)  state_d = ST_WRITE_LO;
      ST_WRITE_LO:   state_d = ST_FILL_TLB;
      ST_FILL_TLB:   state_d = ST_RESUME;
      ST_RESUME:     state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int ROOT_LSB = 22,
  parameter int PAGE_LSB = 12,
  parameter int BASE_W   = 14,
  parameter int BYTE_SH  = 2
) (
  input  logic [VA_W-PAGE_LSB-1:0] vpn,
  input  logic [BASE_W-1:0]        leaf_base,
  input  logic                     pick_leaf,
  output logic [PA_W-1:0]          addr
);

  localparam int ROOT_IDX_W = VA_W - ROOT_LSB;
  localparam int LEAF_IDX_W = ROOT_LSB - PAGE_LSB;
  localparam int ROOT_USE_W = ROOT_IDX_W + BYTE_SH;
  localparam int LEAF_USE_W = BASE_W + LEAF_IDX_W + BYTE_SH;

  logic [ROOT_IDX_W-1:0] root_idx;
  logic [LEAF_IDX_W-1:0] leaf_idx;
  logic [PA_W-1:0]       root_addr;
  logic [PA_W-1:0]       leaf_addr;

  assign root_idx  = vpn[VA_W-PAGE_LSB-1 -: ROOT_IDX_W];
  assign leaf_idx  = vpn[LEAF_IDX_W-1:0];
  assign root_addr = {{(PA_W-ROOT_USE_W){1'b0}}, root_idx, {BYTE_SH{1'b0}}};
  assign leaf_addr = {{(PA_W-LEAF_USE_W){1'b0}}, leaf_base, leaf_idx, {BYTE_SH{1'b0}}};
  assign addr      = pick_leaf ? leaf_addr : root_addr;

endmodule

// File: rtl/ptw_lo_fmt.sv
module ptw_lo_fmt #(
  parameter int DW      = 32,
  parameter int FRAME_W = 20,
  parameter int ATTR_W  = 4
) (
  input  logic [FRAME_W+ATTR_W-1:0] leaf,
  output logic [DW-1:0]             lo_word
);

  localparam int SRC_W = FRAME_W + ATTR_W;
  localparam int PAD_W = DW - SRC_W;

  // frame number moves to the top, attribute nibble follows, low byte cleared
  assign lo_word = {leaf[FRAME_W-1:0], leaf[SRC_W-1:FRAME_W], {PAD_W{1'b0}}};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int DW        = 32,
  parameter int ROOT_LSB  = 22,
  parameter int PAGE_LSB  = 12,
  parameter int BASE_W    = 14,
  parameter int VALID_POS = 31,
  parameter int FRAME_W   = 20,
  parameter int ATTR_W    = 4,
  parameter int CREG_W    = 5,
  parameter int CREG_IDX  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_cyc_o,
  output logic              mem_stb_o,
  output logic              mem_we_o,
  output logic [DW/8-1:0]   mem_sel_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              cop_sel_o,
  output logic              cop_move_o,
  output logic              cop_ret_o,
  output logic [CREG_W-1:0] cop_addr_o,
  output logic [DW-1:0]     cop_data_o,
  output logic              tlb_we_o,
  output logic              page_fault_o,
  output logic              stall_o
);

  localparam int SEL_W   = DW / 8;
  localparam int BYTE_SH = $clog2(SEL_W);
  localparam int KEEP_W  = FRAME_W + ATTR_W;
  localparam int VPN_W   = VA_W - PAGE_LSB;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  walk_state_e state;
  logic        reading;
  logic        capture;
  logic        root_valid_q;
  logic [KEEP_W-1:0] desc_q;
  logic [DW-1:0]     lo_word;
  logic [PA_W-1:0]   rd_addr;

  assign reading = (state == ST_FETCH_ROOT) || (state == ST_FETCH_LEAF);
  assign capture = reading && mem_ack_i;

  // descriptor capture: only the bits a later step consumes are kept
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      root_valid_q <= 1'b0;
      desc_q       <= '0;
    end else if (capture) begin
      root_valid_q <= mem_rdata_i[VALID_POS];
      desc_q       <= mem_rdata_i[KEEP_W-1:0];
    end
  end

  logic rdata_unused;
  logic vaddr_unused;
  assign rdata_unused = ^mem_rdata_i;
  assign vaddr_unused = ^vaddr_i[PAGE_LSB-1:0];

  ptw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .miss       (miss_i),
    .ack        (mem_ack_i),
    .root_valid (root_valid_q),
    .state      (state)
  );

  ptw_addr_gen #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .ROOT_LSB (ROOT_LSB),
    .PAGE_LSB (PAGE_LSB),
    .BASE_W   (BASE_W),
    .BYTE_SH  (BYTE_SH)
  ) u_addr (
    .vpn       (vaddr_i[VA_W-1 -: VPN_W]),
    .leaf_base (desc_q[BASE_W-1:0]),
    .pick_leaf (state == ST_FETCH_LEAF),
    .addr      (rd_addr)
  );

  ptw_lo_fmt #(
    .DW      (DW),
    .FRAME_W (FRAME_W),
    .ATTR_W  (ATTR_W)
  ) u_fmt (
    .leaf    (desc_q),
    .lo_word (lo_word)
  );

  // Moore outputs decoded from the state register
  assign stall_o      = (state != ST_IDLE);
  assign mem_cyc_o    = reading;
  assign mem_stb_o    = reading;
  assign mem_we_o     = 1'b0;
  assign mem_sel_o    = reading ? {SEL_W{1'b1}} : '0;
  assign mem_addr_o   = reading ? rd_addr : '0;
  assign mem_wdata_o  = '0;
  assign cop_move_o   = (state == ST_WRITE_LO);
  assign cop_ret_o    = (state == ST_RESUME);
  assign cop_sel_o    = cop_move_o || cop_ret_o;
  assign cop_addr_o   = cop_move_o ? CREG_W'(CREG_IDX) : '0;
  assign cop_data_o   = cop_move_o ? lo_word : '0;
  assign tlb_we_o     = (state == ST_FILL_TLB);
  assign page_fault_o = (state == ST_FAULT);

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W     = 32,
  parameter int SEL_W    = 4,
  parameter int CREG_W   = 5,
  parameter int CREG_IDX = 2
) (
  input logic              clk,
  input logic              run_n,
  input logic              miss_i,
  input logic              mem_ack_i,
  input logic              mem_cyc_o,
  input logic              mem_stb_o,
  input logic [SEL_W-1:0]  mem_sel_o,
  input logic [PA_W-1:0]   mem_addr_o,
  input logic              cop_sel_o,
  input logic              cop_move_o,
  input logic              cop_ret_o,
  input logic [CREG_W-1:0] cop_addr_o,
  input logic              tlb_we_o,
  input logic              page_fault_o,
  input logic              stall_o
);

  a_r2_miss_starts_read: assert property (@(posedge clk) disable iff (!run_n)
    (!stall_o && miss_i) |=> (mem_cyc_o && stall_o));

  a_r4_read_holds: assert property (@(posedge clk) disable iff (!run_n)
    (mem_cyc_o && !mem_ack_i) |=> (mem_cyc_o && $stable(mem_addr_o)));

  a_r4_read_ends: assert property (@(posedge clk) disable iff (!run_n)
    (mem_cyc_o && mem_ack_i) |=> !mem_cyc_o);

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!run_n)
    page_fault_o |=> (page_fault_o && stall_o && !mem_cyc_o));

  a_r7_move_target: assert property (@(posedge clk) disable iff (!run_n)
    cop_move_o |-> (cop_sel_o && cop_addr_o == CREG_W'(CREG_IDX)));

  a_r8_fill_after_move: assert property (@(posedge clk) disable iff (!run_n)
    cop_move_o |=> tlb_we_o);

  a_r9_return_after_fill: assert property (@(posedge clk) disable iff (!run_n)
    tlb_we_o |=> (!tlb_we_o && cop_ret_o && cop_sel_o));

  a_r9_idle_after_return: assert property (@(posedge clk) disable iff (!run_n)
    cop_ret_o |=> !stall_o);

  a_r10_bus_needs_stall: assert property (@(posedge clk) disable iff (!run_n)
    mem_cyc_o |-> (stall_o && mem_stb_o && mem_sel_o == {SEL_W{1'b1}}));

  a_r11_one_action: assert property (@(posedge clk) disable iff (!run_n)
    $onehot0({cop_move_o, cop_ret_o, tlb_we_o, page_fault_o}));

endmodule

bind ptw_walker ptw_walker_chk #(
  .PA_W     (PA_W),
  .SEL_W    (DW/8),
  .CREG_W   (CREG_W),
  .CREG_IDX (CREG_IDX)
) u_chk (
  .clk          (clk),
  .run_n        (rst_q_n),
  .miss_i       (miss_i),
  .mem_ack_i    (mem_ack_i),
  .mem_cyc_o    (mem_cyc_o),
  .mem_stb_o    (mem_stb_o),
  .mem_sel_o    (mem_sel_o),
  .mem_addr_o   (mem_addr_o),
  .cop_sel_o    (cop_sel_o),
  .cop_move_o   (cop_move_o),
  .cop_ret_o    (cop_ret_o),
  .cop_addr_o   (cop_addr_o),
  .tlb_we_o     (tlb_we_o),
  .page_fault_o (page_fault_o),
  .stall_o      (stall_o)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

  localparam int K_READ = 0, K_COP = 1, K_TLB = 2, K_RET = 3, K_FAULT = 4;

  typedef struct {
    int          kind;
    logic [31:0] a;
    logic [31:0] d;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_i;
  logic [31:0] vaddr_i;
  logic        mem_ack_i;
  logic [31:0] mem_rdata_i;
  logic        mem_cyc_o, mem_stb_o, mem_we_o;
  logic [3:0]  mem_sel_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        cop_sel_o, cop_move_o, cop_ret_o;
  logic [4:0]  cop_addr_o;
  logic [31:0] cop_data_o;
  logic        tlb_we_o, page_fault_o, stall_o;

  int n_chk = 0;
  int n_fail = 0;
  exp_t exp_q[$];

  logic [31:0] mdat [4];
  int rd_cnt = 0;
  int wcnt = 0;
  int wait_n = 0;

  always #2.5 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .vaddr_i(vaddr_i),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .mem_cyc_o(mem_cyc_o), .mem_stb_o(mem_stb_o), .mem_we_o(mem_we_o),
    .mem_sel_o(mem_sel_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .cop_sel_o(cop_sel_o), .cop_move_o(cop_move_o), .cop_ret_o(cop_ret_o),
    .cop_addr_o(cop_addr_o), .cop_data_o(cop_data_o), .tlb_we_o(tlb_we_o),
    .page_fault_o(page_fault_o), .stall_o(stall_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    e.kind = kind; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] root_addr(input logic [31:0] va);
    return {20'b0, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] leaf_addr(input logic [31:0] va, input logic [31:0] d1);
    return {6'b0, d1[13:0], va[21:12], 2'b00};
  endfunction
  function automatic logic [31:0] lo_of(input logic [31:0] d2);
    return {d2[19:0], d2[23:20], 8'h00};
  endfunction

  task automatic push_walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2);
    push(K_READ, root_addr(va), 0);
    if (!d1[31]) push(K_FAULT, 0, 0);
    else begin
      push(K_READ, leaf_addr(va, d1), 0);
      push(K_COP, 32'd2, lo_of(d2));
      push(K_TLB, 0, 0);
      push(K_RET, 0, 0);
    end
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  // memory responder: ack after wait_n strobe cycles, data by read order
  initial begin
    mem_ack_i = 1'b0; mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0; rd_cnt++; wcnt = 0;
      end else if (mem_cyc_o && mem_stb_o) begin
        if (wcnt >= wait_n) begin
          mem_ack_i = 1'b1; mem_rdata_i = mdat[rd_cnt & 3];
        end else wcnt++;
      end
    end
  end

  // monitor: pops expected events as the design produces them
  logic p_cyc = 1'b0, p_pf = 1'b0, p_tlb = 1'b0;
  logic [31:0] p_addr = '0;

  task automatic pop_cmp(input int kind, input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " unexpected event"}, kind, 32'hFFFF_FFFF);
      return;
    end
    e = exp_q.pop_front();
    chk(e.kind == kind, {tag, " event kind"}, kind, e.kind);
    chk(e.a == a, {tag, " address"}, a, e.a);
    chk(e.d == d, {tag, " data"}, d, e.d);
  endtask

  initial begin
    forever begin
      sample();
      if (!rst_n) begin
        p_cyc = 0; p_pf = 0; p_tlb = 0;
      end else begin
        if (mem_cyc_o && !p_cyc) begin
          pop_cmp(K_READ, mem_addr_o, 0, "R3/R6 read");
          chk(mem_stb_o && !mem_we_o && mem_sel_o == 4'hF, "R4 read strobes",
              {mem_stb_o, mem_we_o, mem_sel_o}, 6'b10_1111);
        end
        if (mem_cyc_o && p_cyc)
          chk(mem_addr_o == p_addr, "R4 address held", mem_addr_o, p_addr);
        if (cop_move_o) begin
          pop_cmp(K_COP, 32'(cop_addr_o), cop_data_o, "R7 coprocessor move");
          chk(cop_sel_o, "R7 select with move", cop_sel_o, 1);
        end
        if (tlb_we_o) begin
          pop_cmp(K_TLB, 0, 0, "R8 tlb write");
          chk(!p_tlb, "R8 single cycle", p_tlb, 0);
        end
        if (cop_ret_o) begin
          pop_cmp(K_RET, 0, 0, "R9 return");
          chk(cop_sel_o, "R9 select with return", cop_sel_o, 1);
        end
        if (page_fault_o && !p_pf) pop_cmp(K_FAULT, 0, 0, "R5 fault");
        if (mem_cyc_o || cop_sel_o || tlb_we_o || page_fault_o)
          chk(stall_o, "R10 stall while busy", stall_o, 1);
        if (mem_we_o || mem_wdata_o != 0)
          chk(1'b0, "R10 write side quiet", mem_wdata_o, 0);
        if (!mem_cyc_o && (mem_stb_o || mem_sel_o != 0))
          chk(1'b0, "R10 strobes outside read", {mem_stb_o, mem_sel_o}, 0);
        p_cyc = mem_cyc_o; p_addr = mem_addr_o; p_pf = page_fault_o; p_tlb = tlb_we_o;
      end
    end
  end

  task automatic all_zero(input string tag);
    chk({stall_o, page_fault_o, tlb_we_o, cop_sel_o, cop_move_o, cop_ret_o,
         mem_cyc_o, mem_stb_o, mem_we_o} == 0 && mem_sel_o == 0 && mem_addr_o == 0 &&
        mem_wdata_o == 0 && cop_addr_o == 0 && cop_data_o == 0,
        tag, {stall_o, page_fault_o, cop_sel_o, mem_cyc_o}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; miss_i = 1'b0;
    #1 all_zero("R1 outputs during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) sample();
    all_zero("R1 outputs after reset");
  endtask

  task automatic wait_for(input int which);
    do sample(); while (which == 0 ? !cop_ret_o : !page_fault_o);
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2, input int w);
    vaddr_i = va; mdat[0] = d1; mdat[1] = d2; rd_cnt = 0; wait_n = w;
    push_walk(va, d1, d2);
    @(negedge clk); miss_i = 1'b1;
    sample();
    chk(stall_o && mem_cyc_o, "R2 miss starts root read", {stall_o, mem_cyc_o}, 2'b11);
    @(negedge clk); miss_i = 1'b0;
    if (!d1[31]) begin
      wait_for(1);
      repeat (5) begin
        sample();
        chk(page_fault_o && stall_o && !mem_cyc_o, "R5 fault held, bus idle",
            {page_fault_o, stall_o, mem_cyc_o}, 3'b110);
      end
    end else begin
      wait_for(0);
      sample();
      chk(!stall_o, "R9 idle after return", stall_o, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; miss_i = 1'b0; vaddr_i = 32'h0;
    for (int i = 0; i < 4; i++) mdat[i] = '0;
    do_reset();

    repeat (6) begin
      sample();
      chk(!stall_o && !mem_cyc_o, "R2 idle without miss", {stall_o, mem_cyc_o}, 0);
    end

    walk(32'hABCD_E123, 32'h8000_1234, 32'h00A5_5C3D, 0);
    walk(32'h5432_1FFF, 32'hFFFF_FFFF, 32'hFFF0_000F, 3);
    walk(32'hFFFF_F000, 32'hC000_3FFF, 32'h12F4_5678, 1);

    // back-to-back walks: miss held high through the return (R2 with R9)
    vaddr_i = 32'h0040_3000; rd_cnt = 0; wait_n = 0;
    mdat[0] = 32'h8000_0001; mdat[1] = 32'h0031_1111;
    mdat[2] = 32'h8000_2002; mdat[3] = 32'h0072_2222;
    push_walk(32'h0040_3000, mdat[0], mdat[1]);
    push_walk(32'h0040_3000, mdat[2], mdat[3]);
    @(negedge clk); miss_i = 1'b1;
    wait_for(0);
    sample();
    chk(!stall_o, "R9 one idle cycle between walks", stall_o, 0);
    sample();
    chk(mem_cyc_o && stall_o, "R2 new walk right after return", {mem_cyc_o, stall_o}, 2'b11);
    @(negedge clk); miss_i = 1'b0;
    wait_for(0);
    sample();
    chk(!stall_o, "R9 idle after second walk", stall_o, 0);

    // invalid root descriptor
    walk(32'h8765_4321, 32'h7FFF_FFFF, 32'h0, 2);
    do_reset();
    walk(32'h1357_9BDF, 32'h8000_2AAA, 32'h00FE_DCBA, 0);

    chk(exp_q.size() == 0, "R11 every expected event seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule